// File: doc/BRIEF.md
# Horizontal Sync Activity Monitor and Source Chooser

This block watches two candidate horizontal sync streams: a dedicated sync pin and the sliced sync-on-green output. It reports for each one whether it is toggling. It then picks which of the two feeds the line-locked PLL. A stream counts as alive only while it keeps producing edges. A stream held at a fixed level, high or low, is reported as dead once a programmable number of timebase ticks has passed since its last edge.

The choice of source follows a fixed table. When exactly one stream is alive, that stream is chosen. When both are alive, or neither is, a user priority bit decides. A force bit makes the priority bit decide in every case. Each input passes through a two-flop synchroniser and then an edge detector. One timeout counter per stream counts ticks since that stream's last edge.

Top module: `hsyncSourceSelect`

## Requirements
- R1: After reset, `hsyncActive`, `sogActive` and `ahs` are all 0, which means no activity and the sync pin selected.
- R2: An activity flag (1 = activity detected, 0 = none) goes to 1 exactly three clock cycles after its input changes level: two synchroniser stages and one flag register. An input that never changes never sets its flag.
- R3: A stream held steady high or held steady low is reported as inactive once its timeout has elapsed, and it stays inactive for as long as it holds that level.
- R4: With the timeout set to T (T ≥ 1), a flag stays 1 through T−1 `tick` pulses after the last registered edge. It clears on the T-th tick. Ticks arriving while the flag is 0 have no effect.
- R5: When an edge and the expiring tick reach a stream in the same cycle, the edge wins. The flag stays 1, and the tick count restarts so that T further ticks are needed to clear it.
- R6: `ahs` = 0 selects the sync pin and `ahs` = 1 selects sync-on-green. With `forceSel` = 0, pin-only activity gives `ahs` = 0 and green-only activity gives `ahs` = 1.
- R7: With `forceSel` = 0, when both flags are 1 or both are 0, `ahs` equals `useSog`.
- R8: With `forceSel` = 1, `ahs` equals `useSog` whatever the flags are.
- R9: `ahs` is registered. It takes its new value one clock cycle after a change of the flags, `useSog` or `forceSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hsyncIn | input | 1 | Dedicated horizontal sync input (asynchronous) |
| sogIn | input | 1 | Sync-on-green slicer output (asynchronous) |
| useSog | input | 1 | Priority bit: 1 prefers sync-on-green |
| forceSel | input | 1 | Force bit: `ahs` follows `useSog` unconditionally |
| tick | input | 1 | One-cycle timebase pulse |
| timeoutTicks | input | CNT_W | Number of ticks without an edge before a flag clears |
| hsyncActive | output | 1 | Activity flag of the sync pin |
| sogActive | output | 1 | Activity flag of sync-on-green |
| ahs | output | 1 | Selected source: 0 sync pin, 1 sync-on-green |

## Verification
Two functions can act on a flag in the same cycle: a fresh edge that sets it, and the expiring timebase tick that would clear it. The bench first advances a stream to one tick short of its timeout. It then toggles the input and places the tick exactly two cycles later, so that the tick and the synchronised edge reach the flag register together. The bench expects the flag to stay set. It also expects a full T further ticks to be needed to clear the flag, which shows that the counter restarted rather than carried on.

// File: rtl/hss_pkg.sv
package hss_pkg;
  localparam int NUM_SRC   = 2;
  localparam int SRC_HSYNC = 0;
  localparam int SRC_SOG   = 1;

  // strobes from control to datapath, one bit per source
  typedef struct packed {
    logic [NUM_SRC-1:0] cntClear;
    logic [NUM_SRC-1:0] cntStep;
  } cnt_strobe_t;
endpackage

// File: rtl/hss_datapath.sv
module hss_datapath
  import hss_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   syncIn,
  input  logic [CNT_W-1:0]     timeoutTicks,
  input  cnt_strobe_t          strobe,
  output logic [NUM_SRC-1:0]   edgeSeen,
  output logic [NUM_SRC-1:0]   expire
);
  localparam int WIDE_W = CNT_W + 1;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic [2:0]       pipe;
    logic [CNT_W-1:0] cnt;

    // two synchroniser stages plus one history stage
    always_ff @(posedge clk) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[1:0], syncIn[g]};
    end

    assign edgeSeen[g] = pipe[1] ^ pipe[2];

    // ticks elapsed since the last edge
    always_ff @(posedge clk) begin
      if (!rstN)                 cnt <= '0;
      else if (strobe.cntClear[g]) cnt <= '0;
      else if (strobe.cntStep[g])  cnt <= cnt + 1'b1;
    end

    assign expire[g] = ({1'b0, cnt} + WIDE_W'(1)) >= {1'b0, timeoutTicks};

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.cntClear[g] |=> cnt == '0);
  end
endmodule

// File: rtl/hss_control.sv
module hss_control
  import hss_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               useSog,
  input  logic               forceSel,
  input  logic [NUM_SRC-1:0] edgeSeen,
  input  logic [NUM_SRC-1:0] expire,
  output cnt_strobe_t        strobe,
  output logic [NUM_SRC-1:0] flag,
  output logic               ahs
);
  logic [NUM_SRC-1:0] flagNext;
  logic               ahsNext;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      strobe.cntClear[i] = edgeSeen[i];
      strobe.cntStep[i]  = tick && flag[i] && !edgeSeen[i] && !expire[i];
      if (edgeSeen[i])                       flagNext[i] = 1'b1;
      else if (tick && flag[i] && expire[i]) flagNext[i] = 1'b0;
      else                                   flagNext[i] = flag[i];
    end
  end

  always_comb begin
    if (forceSel)
      ahsNext = useSog;
    else if (flag[SRC_HSYNC] != flag[SRC_SOG])
      ahsNext = flag[SRC_SOG];
    else
      ahsNext = useSog;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag <= '0;
      ahs  <= 1'b0;
    end else begin
      flag <= flagNext;
      ahs  <= ahsNext;
    end
  end

  // R8
  force_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    forceSel |=> ahs == $past(useSog));
  // R6
  pin_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!forceSel && flag == 2'b01) |=> !ahs);
  // R6
  sog_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!forceSel && flag == 2'b10) |=> ahs);

  for (genvar g = 0; g < NUM_SRC; g++) begin : gChk
    // R2
    rise_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flag[g]) |-> $past(edgeSeen[g]));
    // R4
    fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flag[g]) |-> $past(tick));
  end
endmodule

// File: rtl/hsyncSourceSelect.sv
module hsyncSourceSelect
  import hss_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncIn,
  input  logic             sogIn,
  input  logic             useSog,
  input  logic             forceSel,
  input  logic             tick,
  input  logic [CNT_W-1:0] timeoutTicks,
  output logic             hsyncActive,
  output logic             sogActive,
  output logic             ahs
);
  cnt_strobe_t        strobe;
  logic [NUM_SRC-1:0] edgeSeen;
  logic [NUM_SRC-1:0] expire;
  logic [NUM_SRC-1:0] flag;
  logic [NUM_SRC-1:0] syncIn;

  assign syncIn[SRC_HSYNC] = hsyncIn;
  assign syncIn[SRC_SOG]   = sogIn;

  hss_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .timeoutTicks(timeoutTicks),
    .strobe(strobe), .edgeSeen(edgeSeen), .expire(expire)
  );

  hss_control i_control (
    .clk(clk), .rstN(rstN), .tick(tick), .useSog(useSog), .forceSel(forceSel),
    .edgeSeen(edgeSeen), .expire(expire), .strobe(strobe), .flag(flag), .ahs(ahs)
  );

  assign hsyncActive = flag[SRC_HSYNC];
  assign sogActive   = flag[SRC_SOG];
endmodule

// File: tb/test_hsyncSourceSelect.sv
module test_hsyncSourceSelect;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsyncIn = 1'b0, sogIn = 1'b0, useSog = 1'b0, forceSel = 1'b0, tick = 1'b0;
  logic [7:0] timeoutTicks = 8'd2;
  logic hsyncActive, sogActive, ahs;
  int nChecks = 0, nErr = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hsyncSourceSelect #(.CNT_W(8)) i_hsyncSourceSelect (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .sogIn(sogIn), .useSog(useSog),
    .forceSel(forceSel), .tick(tick), .timeoutTicks(timeoutTicks),
    .hsyncActive(hsyncActive), .sogActive(sogActive), .ahs(ahs)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseTick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic flip(input int ch);
    if (ch == 0) hsyncIn = ~hsyncIn;
    else         sogIn   = ~sogIn;
  endtask

  function automatic int flagOf(input int ch);
    return (ch == 0) ? int'(hsyncActive) : int'(sogActive);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    waitN(3);
    // R1 reset state
    check("R1 hsyncActive", hsyncActive, 0);
    check("R1 sogActive", sogActive, 0);
    check("R1 ahs", ahs, 0);
    rstN = 1'b1;
    // R2 steady inputs never set a flag
    waitN(20);
    check("R2 idle hsync", hsyncActive, 0);
    check("R2 idle sog", sogActive, 0);

    // R2 latency per channel
    for (int ch = 0; ch < 2; ch++) begin
      flip(ch);
      waitN(2);
      check("R2 latency before", flagOf(ch), 0);
      waitN(1);
      check("R2 latency at 3", flagOf(ch), 1);
      waitN(1);
    end

    // R4 timeout sweep; R3 held high and held low
    for (int t = 1; t <= 4; t++) begin
      timeoutTicks = 8'(t);
      for (int ch = 0; ch < 2; ch++) begin
        flip(ch);
        waitN(4);
        check("R4 set", flagOf(ch), 1);
        for (int k = 0; k < t - 1; k++) pulseTick();
        check("R4 held T-1", flagOf(ch), 1);
        pulseTick();
        check("R4 cleared at T", flagOf(ch), 0);
        for (int k = 0; k < 3; k++) pulseTick();
        check("R3 steady level", flagOf(ch), 0);
        check("R3 level held", (ch == 0) ? int'(hsyncIn) : int'(sogIn), (t % 2 == 1) ? 0 : 1);
      end
    end

    // R5 edge coinciding with expiring tick
    timeoutTicks = 8'd3;
    for (int ch = 0; ch < 2; ch++) begin
      flip(ch);
      waitN(4);
      pulseTick();
      pulseTick();
      flip(ch);
      waitN(2);
      pulseTick();
      check("R5 edge wins", flagOf(ch), 1);
      pulseTick();
      pulseTick();
      check("R5 restarted count", flagOf(ch), 1);
      pulseTick();
      check("R5 clears after T", flagOf(ch), 0);
    end

    // R6 R7 R8 sweep of flags x priority x force
    timeoutTicks = 8'd2;
    for (int st = 0; st < 4; st++) begin
      int h = st & 1;
      int s = (st >> 1) & 1;
      pulseTick();
      pulseTick();
      if (h == 1) flip(0);
      if (s == 1) flip(1);
      waitN(4);
      check("R6 hsync flag", hsyncActive, h);
      check("R6 sog flag", sogActive, s);
      for (int m = 0; m < 4; m++) begin
        int p = m & 1;
        int f = (m >> 1) & 1;
        int exp = (f == 1) ? p : ((h != s) ? s : p);
        useSog = p[0];
        forceSel = f[0];
        waitN(2);
        if (f == 1) check("R8 forced", ahs, exp);
        else if (h != s) check("R6 single source", ahs, exp);
        else check("R7 tie uses priority", ahs, exp);
      end
    end

    // R9 registered select
    forceSel = 1'b1;
    useSog = 1'b0;
    waitN(2);
    check("R9 setup", ahs, 0);
    useSog = 1'b1;
    #1;
    check("R9 old value before edge", ahs, 0);
    waitN(1);
    check("R9 new value after one cycle", ahs, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule